// File: doc/BRIEF.md
# Serial Channel Command Processor

This block sits behind the one-byte command register of a serial channel. The host writes a command byte, and the block holds it for a configurable processing delay. When the delay ends, the block applies the command's side effects to the channel's control state. Those side effects are:

- changes to the transmit-enable and receive-enable bits of the channel status byte;
- single-cycle clear strobes toward the receive and transmit FIFOs, the DMA status registers, the per-direction flow-control state and the protocol engine;
- on a global reset, a load of the revision register.

The FIFOs, DMA engines and protocol engines are not part of this block. Their presence is represented only by the strobes.

The command register reads back the pending byte while work is outstanding and returns to zero when the command completes. The host polls either this readback or the busy output to learn when the command is done. Some bits take priority over others:

- A global-reset bit masks every other bit in the same byte.
- A channel clear also disables both directions and is ordered ahead of a protocol initialise written with it.
- A disable beats an enable for the same direction.

A byte that sets the mode-restricted bit while the channel is in mode 1 is refused.

Top module: `chancmd_proc`

## Requirements
- R1: After reset, every output is zero: status byte, readback, busy, done, all strobes, revision register and both error flags.
- R2: A write accepted while idle raises busy on the next cycle for exactly DELAY cycles (default 6). The readback shows the byte while busy and shows zero otherwise. Done pulses for one cycle in the cycle where busy falls, and all effects of the command are visible in that cycle.
- R3: A write made while busy is ignored: it is not latched, it has no effect and it causes no extra completion.
- R4: Command bit 7 (global reset) masks all other bits of its byte. On completion it pulses the global reset strobe alone, clears both enable bits and both error flags, and loads the revision register with REV_CODE.
- R5: Command bit 6 (channel clear) pulses the receive-FIFO, transmit-FIFO and DMA-status clear strobes together. It clears both enable bits and does not pulse any flow-control strobe.
- R6: Command bit 5 (protocol initialise), written without bit 6, pulses the protocol-initialise strobe in the completion cycle.
- R7: When bits 6 and 5 are written together, the clear strobes fire when the delay expires and the protocol-initialise strobe fires one cycle later. Busy and the readback stay up for that extra cycle, and done comes with the initialise strobe.
- R8: Bit 4 sets and bit 3 clears the transmit-enable bit, which is status bit 3. Bit 2 sets and bit 1 clears the receive-enable bit, which is status bit 7. All other status bits read zero.
- R9: Within one byte, the clear is applied first and the enable or disable bits are applied after it. A clear written together with an enable therefore leaves that direction enabled.
- R10: With the asynchronous-mode input high at completion, an enable or disable command pulses that direction's flow-control clear strobe. With the input low, neither flow-control strobe fires.
- R11: If enable and disable are both set for one direction, that direction ends disabled and the sticky conflict flag is set.
- R12: While the mode-1 input is high, a byte with bit 0 set is refused: busy stays low, no effect occurs, and the sticky illegal flag is set. Outside mode 1, bit 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_byte_i | input | 8 | Command byte |
| async_mode_i | input | 1 | Channel runs an asynchronous protocol |
| mode1_i | input | 1 | Channel is in mode 1 |
| cmd_rdback_o | output | 8 | Command register readback |
| busy_o | output | 1 | Command pending |
| done_o | output | 1 | One-cycle completion pulse |
| chan_status_o | output | 8 | Status byte: bit 7 receive enable, bit 3 transmit enable |
| rx_fifo_clr_o | output | 1 | Receive FIFO clear strobe |
| tx_fifo_clr_o | output | 1 | Transmit FIFO clear strobe |
| dma_sts_clr_o | output | 1 | DMA status clear strobe |
| tx_flow_clr_o | output | 1 | Transmit flow-control clear strobe |
| rx_flow_clr_o | output | 1 | Receive flow-control clear strobe |
| proto_init_o | output | 1 | Protocol register initialise strobe |
| global_reset_o | output | 1 | Global reset strobe |
| rev_code_o | output | 8 | Revision register |
| conflict_err_o | output | 1 | Sticky enable/disable conflict flag |
| illegal_err_o | output | 1 | Sticky refused-command flag |

## Verification
A write sampled at a clock edge completes DELAY edges later: done, the strobes, the status bits and the cleared readback all appear at that edge. When clear and initialise are combined, completion comes one edge later, and the clear strobes lead the initialise strobe by exactly one cycle. Busy and the readback change at the edge that samples the write. The scoreboard stamps each write with the cycle count, and the monitor compares the cycle of each observed done against the stamp plus the expected latency. Strobes are collected between completions, so a strobe that arrives early, arrives late or is missing is reported.

// File: rtl/chancmd_pkg.sv
package chancmd_pkg;

    localparam int unsigned CMD_W = 8;

    // command byte bit positions
    localparam int unsigned B_RST  = 7;
    localparam int unsigned B_CLR  = 6;
    localparam int unsigned B_INIT = 5;
    localparam int unsigned B_TXE  = 4;
    localparam int unsigned B_TXD  = 3;
    localparam int unsigned B_RXE  = 2;
    localparam int unsigned B_RXD  = 1;
    localparam int unsigned B_M1   = 0;

    // status byte bit positions
    localparam int unsigned ST_RX = 7;
    localparam int unsigned ST_TX = 3;

    typedef struct packed {
        logic rst_all;
        logic clr;
        logic init;
        logic txe;
        logic txd;
        logic rxe;
        logic rxd;
    } cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_TAIL = 2'd2
    } seq_e;

endpackage

// File: rtl/chancmd_decode.sv
module chancmd_decode
    import chancmd_pkg::*;
(
    input  logic [CMD_W-1:0] byte_i,
    input  logic             mode1_i,
    output cmd_t             cmd_o,
    output logic             illegal_o,
    output logic             conflict_o
);

    always_comb begin
        cmd_o         = '0;
        cmd_o.rst_all = byte_i[B_RST];
        if (!byte_i[B_RST]) begin
            cmd_o.clr  = byte_i[B_CLR];
            cmd_o.init = byte_i[B_INIT];
            cmd_o.txe  = byte_i[B_TXE];
            cmd_o.txd  = byte_i[B_TXD];
            cmd_o.rxe  = byte_i[B_RXE];
            cmd_o.rxd  = byte_i[B_RXD];
        end
        illegal_o  = mode1_i && byte_i[B_M1];
        conflict_o = (cmd_o.txe && cmd_o.txd) || (cmd_o.rxe && cmd_o.rxd);
    end

endmodule

// File: rtl/chancmd_seq.sv
module chancmd_seq
    import chancmd_pkg::*;
#(
    parameter int unsigned DELAY = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic split_i,
    output logic busy_o,
    output logic exec_main_o,
    output logic exec_tail_o
);

    localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(DELAY - 1);

    typedef struct packed {
        seq_e          st;
        logic [CW-1:0] cnt;
        logic          split;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    seq_d.st    = SQ_WAIT;
                    seq_d.cnt   = CNT_LOAD;
                    seq_d.split = split_i;
                end
            end
            SQ_WAIT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = seq_q.split ? SQ_TAIL : SQ_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_TAIL: seq_d.st = SQ_IDLE;
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '{st: SQ_IDLE, cnt: '0, split: 1'b0};
        else         seq_q <= seq_d;
    end

    assign busy_o      = (seq_q.st != SQ_IDLE);
    assign exec_main_o = (seq_q.st == SQ_WAIT) && (seq_q.cnt == '0);
    assign exec_tail_o = (seq_q.st == SQ_TAIL);

    // R7: the deferred initialise phase only ever follows the wait phase
    a_r7_tail_after_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == SQ_TAIL) |-> ($past(seq_q.st) == SQ_WAIT));

    // R2: a start taken while idle makes the sequencer busy
    a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);

endmodule

// File: rtl/chancmd_proc.sv
module chancmd_proc
    import chancmd_pkg::*;
#(
    parameter int unsigned DELAY    = 6,
    parameter logic [7:0]  REV_CODE = 8'hC3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cmd_wr_i,
    input  logic [CMD_W-1:0] cmd_byte_i,
    input  logic             async_mode_i,
    input  logic             mode1_i,
    output logic [CMD_W-1:0] cmd_rdback_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CMD_W-1:0] chan_status_o,
    output logic             rx_fifo_clr_o,
    output logic             tx_fifo_clr_o,
    output logic             dma_sts_clr_o,
    output logic             tx_flow_clr_o,
    output logic             rx_flow_clr_o,
    output logic             proto_init_o,
    output logic             global_reset_o,
    output logic [7:0]       rev_code_o,
    output logic             conflict_err_o,
    output logic             illegal_err_o
);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        cmd_t             held;
        logic             tx_en;
        logic             rx_en;
        logic             grst;
        logic             rxf;
        logic             txf;
        logic             dma;
        logic             txfl;
        logic             rxfl;
        logic             init;
        logic             done;
        logic [7:0]       rev;
        logic             conf;
        logic             ill;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    cmd_t dec_cmd;
    logic dec_ill;
    logic dec_conf;
    logic seq_busy;
    logic exec_main;
    logic exec_tail;
    logic accept;
    logic ill_wr;

    chancmd_decode u_dec (
        .byte_i     (cmd_byte_i),
        .mode1_i    (mode1_i),
        .cmd_o      (dec_cmd),
        .illegal_o  (dec_ill),
        .conflict_o (dec_conf)
    );

    assign accept = cmd_wr_i && !seq_busy && !dec_ill;
    assign ill_wr = cmd_wr_i && !seq_busy && dec_ill;

    chancmd_seq #(.DELAY(DELAY)) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (accept),
        .split_i     (dec_cmd.clr && dec_cmd.init),
        .busy_o      (seq_busy),
        .exec_main_o (exec_main),
        .exec_tail_o (exec_tail)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.grst = 1'b0;
        ctl_d.rxf  = 1'b0;
        ctl_d.txf  = 1'b0;
        ctl_d.dma  = 1'b0;
        ctl_d.txfl = 1'b0;
        ctl_d.rxfl = 1'b0;
        ctl_d.init = 1'b0;
        ctl_d.done = 1'b0;

        if (accept) begin
            ctl_d.cmd  = cmd_byte_i;
            ctl_d.held = dec_cmd;
            if (dec_conf) ctl_d.conf = 1'b1;
        end
        if (ill_wr) ctl_d.ill = 1'b1;

        if (exec_main) begin
            if (ctl_q.held.rst_all) begin
                ctl_d.grst  = 1'b1;
                ctl_d.tx_en = 1'b0;
                ctl_d.rx_en = 1'b0;
                ctl_d.conf  = 1'b0;
                ctl_d.ill   = 1'b0;
                ctl_d.rev   = REV_CODE;
            end else begin
                // clear is ordered ahead of the per-direction bits
                if (ctl_q.held.clr) begin
                    ctl_d.rxf   = 1'b1;
                    ctl_d.txf   = 1'b1;
                    ctl_d.dma   = 1'b1;
                    ctl_d.tx_en = 1'b0;
                    ctl_d.rx_en = 1'b0;
                end
                if (ctl_q.held.txd)      ctl_d.tx_en = 1'b0;
                else if (ctl_q.held.txe) ctl_d.tx_en = 1'b1;
                if (ctl_q.held.rxd)      ctl_d.rx_en = 1'b0;
                else if (ctl_q.held.rxe) ctl_d.rx_en = 1'b1;
                ctl_d.txfl = async_mode_i && (ctl_q.held.txe || ctl_q.held.txd);
                ctl_d.rxfl = async_mode_i && (ctl_q.held.rxe || ctl_q.held.rxd);
                if (ctl_q.held.init && !ctl_q.held.clr) ctl_d.init = 1'b1;
            end
            if (!(ctl_q.held.clr && ctl_q.held.init && !ctl_q.held.rst_all)) begin
                ctl_d.cmd  = '0;
                ctl_d.done = 1'b1;
            end
        end

        if (exec_tail) begin
            ctl_d.init = 1'b1;
            ctl_d.cmd  = '0;
            ctl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    always_comb begin
        chan_status_o        = '0;
        chan_status_o[ST_RX] = ctl_q.rx_en;
        chan_status_o[ST_TX] = ctl_q.tx_en;
    end

    assign cmd_rdback_o   = ctl_q.cmd;
    assign busy_o         = seq_busy;
    assign done_o         = ctl_q.done;
    assign rx_fifo_clr_o  = ctl_q.rxf;
    assign tx_fifo_clr_o  = ctl_q.txf;
    assign dma_sts_clr_o  = ctl_q.dma;
    assign tx_flow_clr_o  = ctl_q.txfl;
    assign rx_flow_clr_o  = ctl_q.rxfl;
    assign proto_init_o   = ctl_q.init;
    assign global_reset_o = ctl_q.grst;
    assign rev_code_o     = ctl_q.rev;
    assign conflict_err_o = ctl_q.conf;
    assign illegal_err_o  = ctl_q.ill;

    // R2: readback is zero whenever nothing is pending
    a_r2_rdback_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (cmd_rdback_o == '0));

    // R2: completion coincides with busy dropping
    a_r2_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R3: while busy and not finishing, the readback does not move
    a_r3_rdback_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !exec_main && !exec_tail) |=> $stable(cmd_rdback_o));

    // R4: global reset loads the revision and leaves both directions off
    a_r4_rev_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        global_reset_o |-> (rev_code_o == REV_CODE && chan_status_o == '0));

    // R4: global reset masks every other strobe
    a_r4_masks_others: assert property (@(posedge clk_i) disable iff (!rst_ni)
        global_reset_o |-> !(rx_fifo_clr_o || tx_fifo_clr_o || dma_sts_clr_o ||
                             tx_flow_clr_o || rx_flow_clr_o || proto_init_o));

    // R5: the three clear strobes always move together
    a_r5_clear_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_fifo_clr_o || tx_fifo_clr_o || dma_sts_clr_o) |->
        (rx_fifo_clr_o && tx_fifo_clr_o && dma_sts_clr_o));

    // R10: flow-control strobes only in asynchronous mode
    a_r10_flow_async: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_flow_clr_o || rx_flow_clr_o) |-> $past(async_mode_i));

    // R11: a transmit disable always wins
    a_r11_disable_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_main && !ctl_q.held.rst_all && ctl_q.held.txd) |=> !chan_status_o[ST_TX]);

    // R12: a refused write never starts processing and sets the flag
    a_r12_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr_i && !busy_o && mode1_i && cmd_byte_i[B_M1]) |=> (!busy_o && illegal_err_o));

endmodule

// File: tb/chancmd_proc_tb_top.sv
`timescale 1ns/1ps
module chancmd_proc_tb_top;

    localparam int unsigned DELAY = 6;
    localparam logic [7:0]  REV   = 8'hC3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       async_mode = 1'b0;
    logic       mode1 = 1'b0;
    logic [7:0] rdback, status, rev;
    logic       busy, done, rxf, txf, dma, txfl, rxfl, init, grst, conf, ill;

    always #5 clk = ~clk;

    chancmd_proc #(.DELAY(DELAY), .REV_CODE(REV)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_byte_i(cmd_byte),
        .async_mode_i(async_mode), .mode1_i(mode1), .cmd_rdback_o(rdback),
        .busy_o(busy), .done_o(done), .chan_status_o(status),
        .rx_fifo_clr_o(rxf), .tx_fifo_clr_o(txf), .dma_sts_clr_o(dma),
        .tx_flow_clr_o(txfl), .rx_flow_clr_o(rxfl), .proto_init_o(init),
        .global_reset_o(grst), .rev_code_o(rev), .conflict_err_o(conf),
        .illegal_err_o(ill)
    );

    typedef struct {
        string      tag;
        int         wr_cyc;
        int         lat;
        logic [6:0] strb;   // {grst, rxf, txf, dma, txfl, rxfl, init}
        logic       tx, rx, cf, il;
        logic [7:0] rv;
        logic       split;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    logic m_tx = 0, m_rx = 0, m_cf = 0, m_il = 0;
    logic [7:0] m_rev = '0;
    logic [6:0] acc = '0;
    int   clr_cyc = -1;
    int   init_cyc = -1;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // monitor: collect strobes, pop the scoreboard on each completion
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            acc = acc | {grst, rxf, txf, dma, txfl, rxfl, init};
            if (rxf && clr_cyc < 0) clr_cyc = cyc;
            if (init) init_cyc = cyc;
            if (done) begin
                if (sbq.size() == 0) begin
                    chk(0, "R3", "unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(cyc - e.wr_cyc == e.lat, e.tag, "latency", cyc - e.wr_cyc, e.lat);
                    chk(acc == e.strb, e.tag, "strobes", acc, e.strb);
                    chk(status == {e.rx, 3'b000, e.tx, 3'b000}, e.tag, "status", status,
                        {e.rx, 3'b000, e.tx, 3'b000});
                    chk(busy == 0 && rdback == 0, "R2", "idle at done", {busy, rdback}, 0);
                    chk(conf == e.cf && ill == e.il, e.tag, "flags", {conf, ill}, {e.cf, e.il});
                    chk(rev == e.rv, e.tag, "revision", rev, e.rv);
                    if (e.split)
                        chk(init_cyc == clr_cyc + 1, "R7", "init one cycle after clear",
                            init_cyc - clr_cyc, 1);
                end
                acc = '0;
                clr_cyc = -1;
                init_cyc = -1;
            end
        end
    end

    // driver: predict from the requirements, push, then write the byte
    task automatic issue(input logic [7:0] c, input logic asy, input string tag);
        exp_t e;
        e.tag = tag;
        e.strb = '0;
        e.split = 0;
        if (c[7]) begin
            e.strb = 7'b1000000;
            m_tx = 0; m_rx = 0; m_cf = 0; m_il = 0; m_rev = REV;
        end else begin
            if (c[6]) begin
                e.strb[5] = 1; e.strb[4] = 1; e.strb[3] = 1;
                m_tx = 0; m_rx = 0;
            end
            if (c[3]) m_tx = 0; else if (c[4]) m_tx = 1;
            if (c[1]) m_rx = 0; else if (c[2]) m_rx = 1;
            e.strb[2] = asy && (c[4] || c[3]);
            e.strb[1] = asy && (c[2] || c[1]);
            e.strb[0] = c[5];
            if ((c[4] && c[3]) || (c[2] && c[1])) m_cf = 1;
            e.split = c[6] && c[5];
        end
        e.tx = m_tx; e.rx = m_rx; e.cf = m_cf; e.il = m_il; e.rv = m_rev;
        e.lat = DELAY + 1 + (e.split ? 1 : 0);
        @(negedge clk);
        async_mode = asy;
        e.wr_cyc = cyc;
        sbq.push_back(e);
        cmd_wr = 1;
        cmd_byte = c;
        @(negedge clk);
        cmd_wr = 0;
        cmd_byte = '0;
    endtask

    task automatic wait_idle();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(status == 0 && rdback == 0 && busy == 0 && done == 0, "R1", "outputs",
            {status, rdback, busy, done}, 0);
        chk({grst, rxf, txf, dma, txfl, rxfl, init} == 0 && rev == 0 && !conf && !ill,
            "R1", "strobes/flags", {grst, rxf, txf, dma, txfl, rxfl, init, rev}, 0);

        issue(8'h10, 0, "R8");  wait_idle();  // tx enable, sync: no flow strobe (R10)
        issue(8'h04, 1, "R10"); wait_idle();  // rx enable, async
        issue(8'h08, 1, "R10"); wait_idle();  // tx disable, async
        issue(8'h06, 0, "R11"); wait_idle();  // rx enable+disable
        issue(8'h50, 0, "R9");  wait_idle();  // clear + tx enable
        issue(8'h20, 0, "R6");  wait_idle();  // initialise alone
        issue(8'h44, 1, "R5");  wait_idle();  // clear + rx enable async
        issue(8'h60, 0, "R7");  wait_idle();  // clear + initialise
        issue(8'h01, 0, "R12"); wait_idle();  // bit0 outside mode 1: nothing

        // R3: write while busy is ignored
        issue(8'h10, 0, "R3");
        chk(busy == 1 && rdback == 8'h10, "R2", "busy and readback", {busy, rdback}, 9'h110);
        cmd_wr = 1; cmd_byte = 8'h04;
        @(negedge clk);
        cmd_wr = 0; cmd_byte = '0;
        chk(rdback == 8'h10, "R3", "readback during busy", rdback, 8'h10);
        wait_idle();
        repeat (DELAY + 2) @(negedge clk);
        chk(status[7] == 0, "R3", "rx not enabled", status[7], 0);

        // R12: refused byte in mode 1
        mode1 = 1;
        @(negedge clk);
        cmd_wr = 1; cmd_byte = 8'h0B;
        @(negedge clk);
        cmd_wr = 0; cmd_byte = '0;
        chk(busy == 0 && rdback == 0, "R12", "not accepted", {busy, rdback}, 0);
        chk(ill == 1, "R12", "illegal flag", ill, 1);
        repeat (DELAY + 2) @(negedge clk);
        chk(status[3] == 1, "R12", "tx unchanged", status[3], 1);
        m_il = 1;
        issue(8'h08, 0, "R12"); wait_idle();  // legal in mode 1
        mode1 = 0;

        // R4: global reset masks the other bits
        issue(8'hD4, 1, "R4"); wait_idle();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule